// File: doc/BRIEF.md
# Stepper Microstepping Indexer

This block sequences one bipolar stepper motor from a step/direction command pair. It keeps a position index into a 32-entry table of winding currents spaced 11.25 degrees apart. From that index it produces, for each of the two windings, a current setpoint given as a sign and a magnitude in percent of full scale. A 2-bit mode input picks full, half, quarter or eighth stepping. Each synchronized rising edge of the step input moves the index by the stride of that mode, forward or in reverse.

For every winding the block also reports whether the last step lowered the current magnitude. A downstream decay controller can use that flag to choose its recirculation style. A motor-hold input, a sleep request and a lockout-reset request all park the index at the 45-degree home position, where both windings sit at 71 %. An active-low enable only gates the bridge-enable output. It leaves stepping alive.

Top module: `stepper_indexer`

## Requirements
- R1: The mode select is encoded as 00 = full, 01 = half, 10 = quarter and 11 = eighth step. Each step moves 8, 4, 2 or 1 table positions respectively. In full mode only the positions at 45, 135, 225 and 315 degrees are visited.
- R2: Position p (0..31) stands for p × 11.25 degrees. Winding A carries cos and winding B carries sin of that angle, as magnitudes from the series 100, 98, 92, 83, 71, 56, 38, 20, 0.
- R3: With dirIn high a step increases the angle; with dirIn low it decreases it. The index wraps modulo 32.
- R4: After system reset the index is home (45 degrees, both windings 71 % positive) and both falling flags are 0.
- R5: While holdN is low the index is held at home, step edges are ignored and bridgeEn is 0.
- R6: While enableN is high, bridgeEn is 0, yet steps still move the index. Otherwise bridgeEn is 1 one clock after holdN is high and sleepReq is low.
- R7: While sleepReq is high the index is forced home, steps are ignored and bridgeEn is 0.
- R8: A lockoutReset pulse returns the index to home on the next clock.
- R9: Each sign output is 1 for negative current (OUT2 above OUT1) and 0 otherwise. A zero magnitude always carries sign 0.
- R10: If the index is off the grid of the current mode, the next step first moves to the nearest grid position in the step direction. The grid is offset 4 in full mode and 0 otherwise.
- R11: On each step the falling flag of a winding becomes 1 exactly when the new magnitude is below the previous one. Forcing home clears both flags.
- R12: The setpoint changes on the third rising clock edge after stepIn is first sampled high. Without a step or home request it stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| sysRstN | input | 1 | Asynchronous power-up reset, active low |
| stepIn | input | 1 | Step request; each rising edge advances, asynchronous |
| dirIn | input | 1 | Step direction, 1 = increasing angle |
| modeSel | input | 2 | Step mode select |
| holdN | input | 1 | Motor hold/reset, active low |
| enableN | input | 1 | Bridge enable, active low |
| sleepReq | input | 1 | Sleep request, forces home |
| lockoutReset | input | 1 | Lockout-reset pulse, forces home |
| windAMag | output | 7 | Winding A magnitude in percent |
| windASign | output | 1 | Winding A sign, 1 = negative |
| windBMag | output | 7 | Winding B magnitude in percent |
| windBSign | output | 1 | Winding B sign, 1 = negative |
| windAFalling | output | 1 | Winding A magnitude fell on last step |
| windBFalling | output | 1 | Winding B magnitude fell on last step |
| bridgeEn | output | 1 | Power stage enable |

## Verification
The stepping function is driven through a walk that changes the mode and the direction mid-sequence. The walk covers:
- aligned steps, which separate the stride of each mode;
- off-grid starts after a mode change, in both directions, which separate correct realignment from a plain stride add;
- wraps through position 0, which show the modulo arithmetic.

Each vector checks both signed setpoints and both falling flags. A vector with equal old and new magnitudes separates strict from non-strict comparison. The directed tests apply hold, enable, sleep and lockout while step pulses arrive. They also measure the exact edge on which a step shows at the outputs.

// File: rtl/stepidx_pkg.sv
package stepidx_pkg;
  localparam int IDX_W     = 5;
  localparam int POS_CNT   = 1 << IDX_W;
  localparam int QTR       = POS_CNT / 4;
  localparam int MAG_W     = 7;
  localparam int HOME_IDX  = QTR / 2;
  localparam int WINDINGS  = 2;

  typedef enum logic [1:0] {
    MODE_FULL    = 2'b00,
    MODE_HALF    = 2'b01,
    MODE_QUARTER = 2'b10,
    MODE_EIGHTH  = 2'b11
  } stepMode_e;

  typedef struct packed {
    logic      goHome;
    logic      advance;
    logic      forward;
    stepMode_e mode;
  } idxCmd_t;

  // magnitude of cos for k steps of 11.25 degrees, k in 0..8
  function automatic logic [MAG_W-1:0] foldMag(input logic [3:0] k);
    case (k)
      4'd0:    foldMag = 7'd100;
      4'd1:    foldMag = 7'd98;
      4'd2:    foldMag = 7'd92;
      4'd3:    foldMag = 7'd83;
      4'd4:    foldMag = 7'd71;
      4'd5:    foldMag = 7'd56;
      4'd6:    foldMag = 7'd38;
      4'd7:    foldMag = 7'd20;
      default: foldMag = 7'd0;
    endcase
  endfunction

  function automatic logic [MAG_W-1:0] cosMag(input logic [IDX_W-1:0] pos);
    logic [3:0] r;
    r = pos[3:0];
    cosMag = (r <= 4'd8) ? foldMag(r) : foldMag(4'd0 - r);
  endfunction

  function automatic logic cosNeg(input logic [IDX_W-1:0] pos);
    cosNeg = (pos > IDX_W'(QTR)) && (pos < IDX_W'(3 * QTR));
  endfunction
endpackage

// File: rtl/stepidx_control.sv
module stepidx_control
  import stepidx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        sysRstN,
  input  logic        stepIn,
  input  logic        dirIn,
  input  logic [1:0]  modeSel,
  input  logic        holdN,
  input  logic        enableN,
  input  logic        sleepReq,
  input  logic        lockoutReset,
  output idxCmd_t     cmd,
  output logic        bridgeEn
);
  // synchronizer stages followed by one history flop for edge detection
  logic [SYNC_STAGES:0] syncQ;
  logic stepRise;

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) syncQ <= '0;
    else          syncQ <= {syncQ[SYNC_STAGES-1:0], stepIn};
  end

  assign stepRise = syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES];

  always_comb begin
    cmd.goHome  = ~holdN | sleepReq | lockoutReset;
    cmd.advance = stepRise & ~cmd.goHome;
    cmd.forward = dirIn;
    cmd.mode    = stepMode_e'(modeSel);
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) bridgeEn <= 1'b0;
    else          bridgeEn <= holdN & ~enableN & ~sleepReq;
  end
endmodule

// File: rtl/stepidx_datapath.sv
module stepidx_datapath
  import stepidx_pkg::*;
(
  input  logic                              clk,
  input  logic                              sysRstN,
  input  idxCmd_t                           cmd,
  output logic [WINDINGS-1:0][MAG_W-1:0]    magOut,
  output logic [WINDINGS-1:0]               signOut,
  output logic [WINDINGS-1:0]               fallOut
);
  logic [IDX_W-1:0] idxQ;
  logic [IDX_W-1:0] stride, offset, rel, rem, delta, nextIdx;

  always_comb begin
    case (cmd.mode)
      MODE_FULL:    begin stride = IDX_W'(QTR);     offset = IDX_W'(HOME_IDX); end
      MODE_HALF:    begin stride = IDX_W'(QTR / 2); offset = '0; end
      MODE_QUARTER: begin stride = IDX_W'(QTR / 4); offset = '0; end
      default:      begin stride = IDX_W'(1);       offset = '0; end
    endcase
    rel = idxQ - offset;
    rem = rel & (stride - IDX_W'(1));
    if (cmd.forward) delta = stride - rem;
    else             delta = (rem == '0) ? stride : rem;
    nextIdx = cmd.forward ? idxQ + delta : idxQ - delta;
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)         idxQ <= IDX_W'(HOME_IDX);
    else if (cmd.goHome)  idxQ <= IDX_W'(HOME_IDX);
    else if (cmd.advance) idxQ <= nextIdx;
  end

  // winding w lags winding A by w quarter turns (sin = cos shifted)
  for (genvar w = 0; w < WINDINGS; w++) begin : g_wind
    logic [IDX_W-1:0] curPos, nxtPos;
    logic [MAG_W-1:0] curMag, nxtMag;

    assign curPos = idxQ - IDX_W'(w * QTR);
    assign nxtPos = nextIdx - IDX_W'(w * QTR);
    assign curMag = cosMag(curPos);
    assign nxtMag = cosMag(nxtPos);

    assign magOut[w]  = curMag;
    assign signOut[w] = cosNeg(curPos);

    always_ff @(posedge clk or negedge sysRstN) begin
      if (!sysRstN)         fallOut[w] <= 1'b0;
      else if (cmd.goHome)  fallOut[w] <= 1'b0;
      else if (cmd.advance) fallOut[w] <= (nxtMag < curMag);
    end
  end
endmodule

// File: rtl/stepper_indexer.sv
module stepper_indexer
  import stepidx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             sysRstN,
  input  logic             stepIn,
  input  logic             dirIn,
  input  logic [1:0]       modeSel,
  input  logic             holdN,
  input  logic             enableN,
  input  logic             sleepReq,
  input  logic             lockoutReset,
  output logic [MAG_W-1:0] windAMag,
  output logic             windASign,
  output logic [MAG_W-1:0] windBMag,
  output logic             windBSign,
  output logic             windAFalling,
  output logic             windBFalling,
  output logic             bridgeEn
);
  idxCmd_t idxCmd;
  logic [WINDINGS-1:0][MAG_W-1:0] magVec;
  logic [WINDINGS-1:0]            signVec, fallVec;

  stepidx_control #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .sysRstN(sysRstN), .stepIn(stepIn), .dirIn(dirIn),
    .modeSel(modeSel), .holdN(holdN), .enableN(enableN),
    .sleepReq(sleepReq), .lockoutReset(lockoutReset),
    .cmd(idxCmd), .bridgeEn(bridgeEn)
  );

  stepidx_datapath dp_i (
    .clk(clk), .sysRstN(sysRstN), .cmd(idxCmd),
    .magOut(magVec), .signOut(signVec), .fallOut(fallVec)
  );

  assign windAMag     = magVec[0];
  assign windBMag     = magVec[1];
  assign windASign    = signVec[0];
  assign windBSign    = signVec[1];
  assign windAFalling = fallVec[0];
  assign windBFalling = fallVec[1];
endmodule

// File: rtl/stepper_indexer_chk.sv
module stepper_indexer_chk
  import stepidx_pkg::*;
(
  input logic             clk,
  input logic             sysRstN,
  input logic             holdN,
  input logic             enableN,
  input logic             sleepReq,
  input logic             lockoutReset,
  input idxCmd_t          cmd,
  input logic [MAG_W-1:0] windAMag,
  input logic             windASign,
  input logic [MAG_W-1:0] windBMag,
  input logic             windBSign,
  input logic             windAFalling,
  input logic             windBFalling,
  input logic             bridgeEn
);
  p_full_diag_r1: assert property (@(posedge clk) disable iff (!sysRstN)
    (cmd.advance && cmd.mode == MODE_FULL) |=> (windAMag == 7'd71 && windBMag == 7'd71));

  p_mag_range_r2: assert property (@(posedge clk) disable iff (!sysRstN)
    (windAMag <= 7'd100 && windBMag <= 7'd100));

  p_hold_home_r5: assert property (@(posedge clk) disable iff (!sysRstN)
    !holdN |=> (windAMag == 7'd71 && windBMag == 7'd71 && !windASign && !windBSign && !bridgeEn));

  p_enable_off_r6: assert property (@(posedge clk) disable iff (!sysRstN)
    enableN |=> !bridgeEn);

  p_sleep_home_r7: assert property (@(posedge clk) disable iff (!sysRstN)
    sleepReq |=> (windAMag == 7'd71 && windBMag == 7'd71 && !windASign && !windBSign && !bridgeEn));

  p_lockout_home_r8: assert property (@(posedge clk) disable iff (!sysRstN)
    lockoutReset |=> (windAMag == 7'd71 && windBMag == 7'd71 && !windAFalling && !windBFalling));

  p_zero_sign_r9: assert property (@(posedge clk) disable iff (!sysRstN)
    ((windAMag == 7'd0) |-> !windASign) and ((windBMag == 7'd0) |-> !windBSign));

  p_fall_flag_r11: assert property (@(posedge clk) disable iff (!sysRstN)
    cmd.advance |=> (windAFalling == (windAMag < $past(windAMag)) &&
                     windBFalling == (windBMag < $past(windBMag))));

  p_stable_r12: assert property (@(posedge clk) disable iff (!sysRstN)
    (!cmd.advance && !cmd.goHome) |=> ($stable(windAMag) && $stable(windBMag) &&
      $stable(windASign) && $stable(windBSign) && $stable(windAFalling) && $stable(windBFalling)));
endmodule

bind stepper_indexer stepper_indexer_chk chk_i (
  .clk(clk), .sysRstN(sysRstN), .holdN(holdN), .enableN(enableN),
  .sleepReq(sleepReq), .lockoutReset(lockoutReset), .cmd(idxCmd),
  .windAMag(windAMag), .windASign(windASign), .windBMag(windBMag),
  .windBSign(windBSign), .windAFalling(windAFalling),
  .windBFalling(windBFalling), .bridgeEn(bridgeEn)
);

// File: tb/stepper_indexer_tb_top.sv
`timescale 1ns/1ps
module stepper_indexer_tb_top;
  logic clk = 1'b0;
  logic sysRstN = 1'b0;
  logic stepIn = 1'b0, dirIn = 1'b1;
  logic [1:0] modeSel = 2'b11;
  logic holdN = 1'b1, enableN = 1'b0, sleepReq = 1'b0, lockoutReset = 1'b0;
  logic [6:0] windAMag, windBMag;
  logic windASign, windBSign, windAFalling, windBFalling, bridgeEn;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  stepper_indexer dut_i (
    .clk(clk), .sysRstN(sysRstN), .stepIn(stepIn), .dirIn(dirIn),
    .modeSel(modeSel), .holdN(holdN), .enableN(enableN),
    .sleepReq(sleepReq), .lockoutReset(lockoutReset),
    .windAMag(windAMag), .windASign(windASign), .windBMag(windBMag),
    .windBSign(windBSign), .windAFalling(windAFalling),
    .windBFalling(windBFalling), .bridgeEn(bridgeEn)
  );

  // walk: mode, dir, expected signed A, signed B, fall A, fall B
  localparam int VN = 17;
  localparam logic [1:0] vMode[VN] = '{2'b11, 2'b11, 2'b10, 2'b10, 2'b01, 2'b01, 2'b01, 2'b00,
                                       2'b00, 2'b00, 2'b11, 2'b01, 2'b00, 2'b10, 2'b00, 2'b11, 2'b00};
  localparam logic vDir[VN] = '{1, 1, 1, 0, 0, 0, 0, 0, 1, 1, 0, 1, 1, 1, 1, 1, 0};
  localparam int vA[VN] = '{56, 38, 0, 38, 71, 100, 71, -71, 71, 71, 83, 71, -71, -92, -71, -56, -71};
  localparam int vB[VN] = '{83, 92, 100, 92, 71, 0, -71, -71, -71, 71, 56, 71, 71, 38, -71, -83, -71};
  localparam logic vFa[VN] = '{1, 1, 1, 0, 0, 0, 1, 0, 0, 0, 0, 1, 0, 0, 1, 1, 0};
  localparam logic vFb[VN] = '{0, 0, 0, 1, 1, 1, 0, 0, 0, 0, 1, 0, 0, 1, 0, 0, 1};

  function automatic int sval(input logic [6:0] m, input logic s);
    return s ? -int'(m) : int'(m);
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic stepPulse();
    stepIn = 1'b1;
    repeat (4) @(negedge clk);
    stepIn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic chkHome(input string what);
    chk({what, " A"}, sval(windAMag, windASign), 71);
    chk({what, " B"}, sval(windBMag, windBSign), 71);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    sysRstN = 1'b1;
    repeat (2) @(negedge clk);
    // R4 reset state
    chkHome("R4 reset");
    chk("R4 fallA", int'(windAFalling), 0);
    chk("R4 fallB", int'(windBFalling), 0);
    chk("R6 bridge on", int'(bridgeEn), 1);

    // R1 R2 R3 R10 R11 walk
    for (int i = 0; i < VN; i++) begin
      modeSel = vMode[i];
      dirIn = vDir[i];
      stepPulse();
      chk($sformatf("R1 R2 R3 R10 vec%0d A", i), sval(windAMag, windASign), vA[i]);
      chk($sformatf("R1 R2 R3 R10 vec%0d B", i), sval(windBMag, windBSign), vB[i]);
      chk($sformatf("R11 vec%0d fallA", i), int'(windAFalling), int'(vFa[i]));
      chk($sformatf("R11 vec%0d fallB", i), int'(windBFalling), int'(vFb[i]));
      if (vA[i] == 0) chk("R9 zero sign A", int'(windASign), 0);
      if (vB[i] == 0) chk("R9 zero sign B", int'(windBSign), 0);
    end

    // R5 hold
    holdN = 1'b0;
    @(negedge clk);
    chk("R5 bridge off", int'(bridgeEn), 0);
    chkHome("R5 hold home");
    chk("R5 fallB cleared", int'(windBFalling), 0);
    modeSel = 2'b11; dirIn = 1'b1;
    stepPulse();
    holdN = 1'b1;
    repeat (2) @(negedge clk);
    chkHome("R5 step ignored");
    chk("R5 bridge back", int'(bridgeEn), 1);

    // R6 enable high still steps
    enableN = 1'b1;
    @(negedge clk);
    chk("R6 bridge off", int'(bridgeEn), 0);
    stepPulse();
    chk("R6 steps A", sval(windAMag, windASign), 56);
    chk("R6 steps B", sval(windBMag, windBSign), 83);
    enableN = 1'b0;
    @(negedge clk);
    chk("R6 bridge on again", int'(bridgeEn), 1);

    // R8 lockout reset
    lockoutReset = 1'b1;
    @(negedge clk);
    lockoutReset = 1'b0;
    chkHome("R8 lockout");
    chk("R8 fallA cleared", int'(windAFalling), 0);

    // R7 sleep
    stepPulse();
    chk("R7 pre A", sval(windAMag, windASign), 56);
    sleepReq = 1'b1;
    @(negedge clk);
    chkHome("R7 sleep home");
    chk("R7 bridge off", int'(bridgeEn), 0);
    stepPulse();
    chkHome("R7 step ignored");
    sleepReq = 1'b0;
    repeat (2) @(negedge clk);
    chkHome("R7 after wake");
    chk("R7 bridge on", int'(bridgeEn), 1);

    // R12 latency: change lands on third rising edge after first sample
    stepIn = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 not yet", int'(windAMag), 71);
    @(negedge clk);
    chk("R12 now", int'(windAMag), 56);
    repeat (3) @(negedge clk);
    stepIn = 1'b0;
    repeat (4) @(negedge clk);
    chk("R12 stable", int'(windAMag), 56);

    finishRun();
  end
endmodule